// File: doc/BRIEF.md
# Continuous Capture Ring Buffer

This block takes a serial bit stream, groups every eight accepted bits into a byte (first bit received lands in the most significant position) and stores each byte in an on-chip memory that is addressed as a circle. The writer never waits and never stops: once the memory has been used up it simply continues from the first location and overwrites the oldest bytes. Software follows the stream through a small synchronous register bus. It can read where the writer is and where the reader is, see how many bytes are pending, take bytes out one at a time, or throw away everything unread by moving its reader to the writer's position.

Both positions are kept as counters wider than the memory address. Only the low bits select a memory location, so software can use the upper bits to count laps and spot lost data on its own. A sticky overrun flag, also brought out on a pin for debug, records that the writer has reached the reader's location.

The bit grouping is run by a two-state machine. State PK_EMPTY holds no partial byte; the transition "first bit" (a bit accepted while empty) goes to PK_FILLING. State PK_FILLING collects bits; the transition "byte complete" (the eighth bit accepted) issues a one-cycle byte strobe and returns to PK_EMPTY. An accepted bit that is not the eighth keeps PK_FILLING, and a cycle with no accepted bit keeps either state.

Top module: `cap_ring_top`

## Requirements
- R1: A bit is accepted only in a cycle with `bit_en` high; every eight accepted bits, with any number of idle cycles between them, form one byte whose bit 7 is the first accepted bit and bit 0 the last.
- R2: Each byte is stored at the location given by the low ADDR_W bits of the write count, after which the write count rises by one and wraps only at 2^CNT_W; a read of address 1 returns the full CNT_W-bit write count.
- R3: A read of address 0 returns, in the cycle after the request, the byte stored at the read count's location, and the read count rises by one (post-increment pop); a pop is never refused, even with nothing pending.
- R4: A read of address 2 returns the full CNT_W-bit read count.
- R5: A read of address 3 returns write count minus read count modulo 2^CNT_W.
- R6: A write to address 5 copies the write count into the read count and clears the overrun flag, so the pending count becomes zero.
- R7: When a stored byte leaves the low ADDR_W bits of the updated write count equal to those of the updated read count, the overrun flag is set; it stays set until an address-5 write, is driven on `overrun_o`, and is returned in bit 0 of a read of address 4.
- R8: Writes to any address other than 5 change nothing, and reads of addresses 1 to 7 leave both counts unchanged; reads of addresses 5 to 7 return zero.
- R9: A synchronous active-high reset clears both counts, the overrun flag, the bit grouping and the read data output.
- R10: A pop and a byte store in the same cycle both take effect, and the overrun compare uses the read count after that pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 3 | Register address (0 data, 1 write count, 2 read count, 3 pending, 4 status, 5 command) |
| bus_rdata | output | CNT_W | Read data, valid the cycle after a read request |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A wrong bit count or shift direction in the grouping machine shows as a wrong byte on the first pop after eight bits and as a write count that moves too early or too late, visible within two cycles of the eighth bit. A pointer that slips or wraps early shows at once in the write count, read count or pending registers and, one pop later, as a byte out of order against the scoreboard. A compare done on stale pointers shows as the overrun pin rising one byte early when a pop and a store coincide, or not rising after the 257th byte since a resynchronisation.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

    typedef enum logic [2:0] {
        RA_DATA = 3'd0,
        RA_WPTR = 3'd1,
        RA_RPTR = 3'd2,
        RA_FILL = 3'd3,
        RA_STAT = 3'd4,
        RA_CMD  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        PK_EMPTY,
        PK_FILLING
    } pk_state_e;

endpackage

// File: rtl/cap_bit_packer.sv
module cap_bit_packer
    import cap_ring_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_en,
    input  logic            bit_in,
    output logic            byte_vld,
    output logic [BITS-1:0] byte_data
);
    localparam int CW = $clog2(BITS);

    pk_state_e       state, nstate;
    logic [CW-1:0]   cnt;
    logic [BITS-1:0] sh;
    logic            last;

    assign last = (cnt == CW'(BITS - 1));

    always_comb begin
        nstate = state;
        unique case (state)
            PK_EMPTY:   if (bit_en) nstate = PK_FILLING;
            PK_FILLING: if (bit_en && last) nstate = PK_EMPTY;
            default:    nstate = PK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PK_EMPTY;
        else     state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            sh        <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (bit_en) begin
                sh <= {sh[BITS-2:0], bit_in};
                if (last) begin
                    byte_data <= {sh[BITS-2:0], bit_in};
                    byte_vld  <= 1'b1;
                    cnt       <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R1: a byte needs several accepted bits, never two strobes back to back
    a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);
    // R1: a strobe follows an accepted bit
    a_r1_strobe_after_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_vld) |-> $past(bit_en));
    // R1: the empty state holds no partial bits
    a_r1_empty_count: assert property (@(posedge clk) disable iff (rst)
        (state == PK_EMPTY) |-> (cnt == '0));

endmodule

// File: rtl/cap_ring_mem.sv
module cap_ring_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/cap_ring_ptrs.sv
module cap_ring_ptrs #(
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_we,
    input  logic          pop,
    input  logic          resync,
    output logic [CW-1:0] wcnt,
    output logic [CW-1:0] rcnt,
    output logic          overrun
);
    logic [CW-1:0] w_nx, r_nx;
    logic          hit;

    always_comb begin
        w_nx = byte_we ? wcnt + CW'(1) : wcnt;
        if (resync)   r_nx = wcnt;
        else if (pop) r_nx = rcnt + CW'(1);
        else          r_nx = rcnt;
        hit = byte_we && (w_nx[AW-1:0] == r_nx[AW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt    <= '0;
            rcnt    <= '0;
            overrun <= 1'b0;
        end else begin
            wcnt <= w_nx;
            rcnt <= r_nx;
            if (hit)         overrun <= 1'b1;
            else if (resync) overrun <= 1'b0;
        end
    end

    // R2: one step per stored byte
    a_r2_write_step: assert property (@(posedge clk) disable iff (rst)
        byte_we |=> (wcnt == $past(wcnt) + CW'(1)));
    a_r2_write_hold: assert property (@(posedge clk) disable iff (rst)
        !byte_we |=> $stable(wcnt));
    // R3: pop advances the reader
    a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
        (pop && !resync) |=> (rcnt == $past(rcnt) + CW'(1)));
    // R6: resync copies the writer position
    a_r6_resync_copy: assert property (@(posedge clk) disable iff (rst)
        resync |=> (rcnt == $past(wcnt)));
    // R7: flag only rises on a store, and is sticky
    a_r7_set_on_store: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(byte_we));
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !resync) |=> overrun);
    // R10: a coincident pop and store both land
    a_r10_both_move: assert property (@(posedge clk) disable iff (rst)
        (pop && byte_we && !resync) |=> (wcnt - rcnt == $past(wcnt) - $past(rcnt)));

endmodule

// File: rtl/cap_ring_top.sv
module cap_ring_top
    import cap_ring_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16,
    parameter int BITS   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             overrun_o
);
    reg_addr_e        ra;
    logic             rd_req, pop, resync;
    logic             byte_vld;
    logic [BITS-1:0]  byte_data, mem_q;
    logic [CNT_W-1:0] wcnt, rcnt, val_q;
    logic             overrun, is_data_q;

    assign ra     = reg_addr_e'(bus_addr);
    assign rd_req = bus_sel && !bus_we;
    assign pop    = rd_req && (ra == RA_DATA);
    assign resync = bus_sel && bus_we && (ra == RA_CMD);

    cap_bit_packer #(.BITS(BITS)) u_pack (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .byte_vld(byte_vld), .byte_data(byte_data)
    );

    cap_ring_mem #(.AW(ADDR_W), .DW(BITS)) u_mem (
        .clk(clk), .we(byte_vld), .waddr(wcnt[ADDR_W-1:0]), .wdata(byte_data),
        .re(pop), .raddr(rcnt[ADDR_W-1:0]), .rdata(mem_q)
    );

    cap_ring_ptrs #(.AW(ADDR_W), .CW(CNT_W)) u_ptrs (
        .clk(clk), .rst(rst), .byte_we(byte_vld), .pop(pop), .resync(resync),
        .wcnt(wcnt), .rcnt(rcnt), .overrun(overrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q     <= '0;
            is_data_q <= 1'b0;
        end else if (rd_req) begin
            is_data_q <= pop;
            unique case (ra)
                RA_WPTR: val_q <= wcnt;
                RA_RPTR: val_q <= rcnt;
                RA_FILL: val_q <= wcnt - rcnt;
                RA_STAT: val_q <= CNT_W'(overrun);
                default: val_q <= '0;
            endcase
        end
    end

    assign bus_rdata = is_data_q ? CNT_W'(mem_q) : val_q;
    assign overrun_o = overrun;

    // R8: a write elsewhere than the command address leaves the reader alone
    a_r8_other_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && ra != RA_CMD) |=> $stable(rcnt));
    // R3: a data read is answered from memory in the next cycle
    a_r3_data_path: assert property (@(posedge clk) disable iff (rst)
        pop |=> is_data_q);

endmodule

// File: tb/cap_ring_top_tb.sv
module cap_ring_top_tb;
    import cap_ring_pkg::*;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_en = 1'b0, bit_in = 1'b0;
    logic             bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]       bus_addr = 3'd0;
    logic [CNT_W-1:0] bus_rdata;
    logic             overrun_o;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    cap_ring_top u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .overrun_o(overrun_o)
    );

    task automatic chk(input string tag, input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: serial byte, first bit is bit 7; optional idle gap after 4 bits
    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            bit_en = 1'b1; bit_in = v[i];
            if (i == 4 && gap > 0) begin
                @(negedge clk);
                bit_en = 1'b0;
                idle(gap - 1);
            end
        end
        @(negedge clk);
        bit_en = 1'b0;
        exp_q.push_back(v);
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [CNT_W-1:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic bus_wr(input logic [2:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [CNT_W-1:0] exp);
        logic [CNT_W-1:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    // monitor side of the scoreboard: a pop is compared with the oldest expected byte
    task automatic pop_chk(input string tag);
        logic [CNT_W-1:0] v;
        logic [7:0] e;
        bus_rd(3'd0, v);
        e = exp_q.pop_front();
        chk(tag, v, {8'h00, e});
    endtask

    // last bit sampled at edge A; pop request captured at edge B with the store
    task automatic send_byte_pop(input logic [7:0] v, input string tag);
        logic [7:0] e;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            bit_en = 1'b1; bit_in = v[i];
        end
        @(negedge clk);
        bit_en = 1'b0;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
        exp_q.push_back(v);
        @(negedge clk);
        bus_sel = 1'b0;
        e = exp_q.pop_front();
        chk(tag, bus_rdata, {8'h00, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] v;
        idle(4);
        rst = 1'b0;
        idle(2);

        // R9 reset state
        chk("R9 rdata after reset", bus_rdata, 16'h0);
        chk("R9 overrun pin", {15'h0, overrun_o}, 16'h0);
        rd_chk("R9 wptr", 3'd1, 16'h0);
        rd_chk("R9 rptr", 3'd2, 16'h0);
        rd_chk("R9 fill", 3'd3, 16'h0);
        rd_chk("R9 status", 3'd4, 16'h0);

        // R1 R2 R3 R4 R5 basic stream
        send_byte(8'hA5, 0);
        send_byte(8'h3C, 0);
        send_byte(8'h81, 0);
        idle(2);
        rd_chk("R2 wptr after 3 bytes", 3'd1, 16'd3);
        rd_chk("R5 fill 3", 3'd3, 16'd3);
        pop_chk("R1 R3 pop A5");
        pop_chk("R3 pop 3C");
        pop_chk("R3 pop 81");
        rd_chk("R4 rptr 3", 3'd2, 16'd3);
        rd_chk("R5 fill 0", 3'd3, 16'd0);

        // R1 idle gap inside a byte
        send_byte(8'h6E, 5);
        idle(2);
        rd_chk("R1 wptr after gapped byte", 3'd1, 16'd4);
        pop_chk("R1 gapped byte");

        // R8 ignored accesses
        bus_wr(3'd1);
        bus_wr(3'd2);
        bus_wr(3'd3);
        rd_chk("R8 unused addr reads zero", 3'd6, 16'd0);
        rd_chk("R8 rptr unchanged", 3'd2, 16'd4);
        rd_chk("R8 wptr unchanged", 3'd1, 16'd4);

        // R6 resync drops unread bytes
        send_byte(8'h11, 0);
        send_byte(8'h22, 0);
        idle(2);
        rd_chk("R5 fill 2", 3'd3, 16'd2);
        bus_wr(3'd5);
        exp_q.delete();
        rd_chk("R6 rptr equals wptr", 3'd2, 16'd6);
        rd_chk("R6 fill zero", 3'd3, 16'd0);

        // R3 R5 pop with nothing pending still advances
        bus_rd(3'd0, v);
        rd_chk("R5 fill wraps", 3'd3, 16'hFFFF);
        rd_chk("R3 rptr after empty pop", 3'd2, 16'd7);
        bus_wr(3'd5);
        rd_chk("R6 rptr back", 3'd2, 16'd6);

        // R7 R10 overrun window
        for (int i = 0; i < 255; i++) send_byte(8'((i * 7 + 1) & 8'hFF), 0);
        idle(2);
        chk("R7 no overrun at 255", {15'h0, overrun_o}, 16'h0);
        rd_chk("R5 fill 255", 3'd3, 16'd255);
        send_byte_pop(8'hF0, "R10 coincident pop data");
        idle(2);
        chk("R10 no overrun with coincident pop", {15'h0, overrun_o}, 16'h0);
        rd_chk("R10 fill unchanged", 3'd3, 16'd255);
        send_byte(8'h0F, 0);
        idle(2);
        chk("R7 overrun pin set", {15'h0, overrun_o}, 16'h1);
        rd_chk("R7 status bit0", 3'd4, 16'h1);
        rd_chk("R2 wptr high bits", 3'd1, 16'd263);
        pop_chk("R7 oldest unread intact");
        idle(2);
        chk("R7 sticky after pop", {15'h0, overrun_o}, 16'h1);
        bus_wr(3'd5);
        exp_q.delete();
        idle(1);
        chk("R6 overrun cleared", {15'h0, overrun_o}, 16'h0);
        rd_chk("R6 status cleared", 3'd4, 16'h0);
        rd_chk("R6 fill after clear", 3'd3, 16'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule